// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives an outgoing parallel data port from a ring of transmit descriptors held in a small on-chip descriptor memory. Each descriptor is four 16-bit words: a status and control word, a byte count, and a 32-bit buffer address split over two words. When enabled, the engine reads the descriptor at its current ring position. If hardware owns it, the engine fetches the referenced bytes through a buffer-memory read port and presents them one data unit at a time on a valid/ready output, marking the last unit of a frame. It then writes the status word back and moves to the next ring position.

Software fills descriptors and hands them over by setting the ownership bit. It watches two sticky event flags: a buffer-done flag and a transmit-error flag. Both are cleared by writing ones, and both can be routed to a single interrupt line through a mask. A descriptor can be marked for continuous use, so the same buffer is sent again on every pass around the ring. When the engine meets a descriptor that software still owns, it flags an error and parks on that descriptor until it receives a poll strobe.

The port width is 8 or 16 bits, chosen by a parameter. Byte-aligned buffers are legal only with the 8-bit port.

Top module: `txring_engine`

## Requirements
- R1: Descriptor k of the ring lives at descriptor-memory word addresses tbl_base+4k+0..3, holding status, byte length, buffer address bits 31:16 and buffer address bits 15:0. The engine reads them in that order with one cycle of read latency. A read and a write to descriptor memory never happen in the same cycle.
- R2: Status bit 15 marks hardware ownership. If the engine reads a status word with bit 15 clear, it sets event bit 1 (error), writes nothing, sends nothing, and stays on that descriptor. It reads the same descriptor again only after a poll strobe.
- R3: Bytes leave in ascending address order. bm_addr is always even and bm_rdata returns the byte at bm_addr in bits 7:0 and the byte at bm_addr+1 in bits 15:8. With an 8-bit port each unit is one byte. With a 16-bit port the lower-addressed byte is in bits 7:0, and when the length is odd the final unit carries its single byte in bits 7:0 with bits 15:8 zero.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_end stay stable.
- R5: If status bit 11 (last of frame) is set, out_end is asserted with the final unit of that descriptor and with no other unit. It is never asserted when bit 11 is clear.
- R6: After a successful send, the status word is written back with bit 15 cleared and every other bit unchanged. If bit 9 (continuous) is set, bit 15 is written back as 1, so the buffer is sent again on the next pass.
- R7: After a descriptor whose status bit 13 (wrap) is set, the next descriptor read is at tbl_base. Otherwise it is the following descriptor.
- R8: Status bit 12 (interrupt) sets event bit 0 when the descriptor closes successfully. A descriptor that closes without bit 12, or closes with an error, leaves event bit 0 unchanged.
- R9: With a 16-bit port, an odd buffer address closes the descriptor with no data sent. Bit 15 is written back cleared even when bit 9 is set, event bit 1 is set, and the engine advances as in R7.
- R10: A descriptor with length zero sends no unit and is closed as in R6.
- R11: Event bits are cleared by reset. Each bit stays set until a cycle with evt_clr_we high and a 1 in the matching evt_clr bit, and a new event in the same cycle wins over the clear. irq is high exactly when a set event bit has its evt_mask bit set.
- R12: Reserved status bits 14, 10 and 8:4 have no effect on transmission and are written back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Allows the engine to start a new descriptor |
| poll | input | 1 | Strobe that releases a parked engine to re-read its descriptor |
| tbl_base | input | DA_W | Descriptor-memory word address of ring entry 0 |
| dm_addr | output | DA_W | Descriptor-memory word address |
| dm_rd | output | 1 | Descriptor-memory read strobe (data next cycle) |
| dm_wr | output | 1 | Descriptor-memory write strobe |
| dm_wdata | output | 16 | Descriptor-memory write data |
| dm_rdata | input | 16 | Descriptor-memory read data |
| bm_addr | output | BA_W | Buffer-memory byte address (even) |
| bm_rd | output | 1 | Buffer-memory read strobe (data next cycle) |
| bm_rdata | input | 16 | Buffer-memory read data |
| out_valid | output | 1 | Output unit valid |
| out_ready | input | 1 | Output unit accepted |
| out_data | output | PORT_W | Output data unit |
| out_end | output | 1 | Final unit of a frame |
| evt_clr_we | input | 1 | Event clear strobe |
| evt_clr | input | 2 | Write-one-to-clear bits for the events |
| evt_mask | input | 2 | Interrupt enable per event |
| evt | output | 2 | Sticky events: bit 0 buffer done, bit 1 error |
| irq | output | 1 | Masked OR of events |

## Verification
The bench builds two copies of the engine side by side, one with PORT_W=16 and one with PORT_W=8, both with DA_W=8 and BA_W=32. The 16-bit copy covers halfword packing, trailing single bytes, the rejected odd pointer and continuous resend across a wrap. The 8-bit copy sends from an odd start address, and also covers zero-length descriptors and reserved status bits. Both ring bases are non-zero, so address arithmetic against tbl_base is exercised. The output handshake is throttled in a fixed pattern, so stalls occur in every data phase.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // status word bit positions (bit 15 is the most significant)
  localparam int ST_RDY  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_INT  = 12;
  localparam int ST_LAST = 11;
  localparam int ST_CONT = 9;

  // event bit positions
  localparam int EV_DONE = 0;
  localparam int EV_ERR  = 1;
  localparam int EV_N    = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_CHK, S_FETCH, S_CAP, S_SEND, S_WB
  } seq_t;

  // status word written back when a descriptor is closed
  function automatic logic [15:0] close_status(input logic [15:0] st, input logic err);
    logic [15:0] r;
    r = st;
    if (err || !st[ST_CONT]) r[ST_RDY] = 1'b0;
    return r;
  endfunction

  // buffer pointer legality against the port width
  function automatic logic ptr_ok(input logic lsb, input int pw);
    return (pw == 8) || !lsb;
  endfunction

endpackage

// File: rtl/txr_events.sv
module txr_events #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] evt,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      evt[i] <= 1'b0;
      else if (set[i]) evt[i] <= 1'b1;
      else if (clr_we && clr[i]) evt[i] <= 1'b0;
    end
  end

  assign irq = |(evt & mask);

endmodule

// File: rtl/txr_unit.sv
module txr_unit #(
  parameter int PORT_W = 16,
  parameter int BA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BA_W-1:0]   ld_ptr,
  input  logic [15:0]       ld_len,
  input  logic              cap,
  input  logic [15:0]       bm_rdata,
  input  logic              adv,
  output logic [BA_W-1:0]   bm_addr,
  output logic              last_u,
  output logic [PORT_W-1:0] unit_data
);

  localparam int STEP = PORT_W / 8;

  logic [BA_W-1:0] addr;
  logic [15:0]     left;
  logic [15:0]     hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= ld_ptr;
      left <= ld_len;
    end else if (adv) begin
      addr <= addr + BA_W'(STEP);
      left <= (left > 16'(STEP)) ? left - 16'(STEP) : 16'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hold <= '0;
    else if (cap) hold <= bm_rdata;
  end

  assign last_u = (left <= 16'(STEP));

  if (PORT_W == 8) begin : g_byte
    assign bm_addr   = {addr[BA_W-1:1], 1'b0};
    assign unit_data = addr[0] ? hold[15:8] : hold[7:0];
  end else begin : g_half
    assign bm_addr   = addr;
    assign unit_data = (left == 16'd1) ? {8'h00, hold[7:0]} : hold;
  end

endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DA_W   = 8,
  parameter int BA_W   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            poll,
  input  logic [DA_W-1:0] tbl_base,
  output logic [DA_W-1:0] dm_addr,
  output logic            dm_rd,
  output logic            dm_wr,
  output logic [15:0]     dm_wdata,
  input  logic [15:0]     dm_rdata,
  output logic            bm_rd,
  output logic            u_load,
  output logic [BA_W-1:0] u_ptr,
  output logic [15:0]     u_len,
  output logic            u_cap,
  output logic            u_adv,
  input  logic            u_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_end,
  output logic            ev_notready,
  output logic            ev_oddptr,
  output logic            ev_close,
  output logic            ev_done
);

  localparam int IDX_W = DA_W - 2;

  seq_t             state, nxt;
  logic [IDX_W-1:0] idx;
  logic             halted, err_q;
  logic [15:0]      st_q, len_q, ptr_hi;
  logic [1:0]       woff;
  logic [31:0]      ptr_full;

  assign ptr_full = {ptr_hi, dm_rdata};
  assign u_ptr    = ptr_full[BA_W-1:0];
  assign u_len    = len_q;

  always_comb begin
    nxt         = state;
    dm_rd       = 1'b0;
    dm_wr       = 1'b0;
    woff        = 2'd0;
    bm_rd       = 1'b0;
    u_load      = 1'b0;
    u_cap       = 1'b0;
    u_adv       = 1'b0;
    out_valid   = 1'b0;
    ev_notready = 1'b0;
    ev_oddptr   = 1'b0;
    ev_close    = 1'b0;
    unique case (state)
      S_IDLE: if (enable && (!halted || poll)) nxt = S_RD0;
      S_RD0: begin
        dm_rd = 1'b1;
        woff  = 2'd0;
        nxt   = S_RD1;
      end
      S_RD1: begin
        if (!dm_rdata[ST_RDY]) begin
          ev_notready = 1'b1;
          nxt         = S_IDLE;
        end else begin
          dm_rd = 1'b1;
          woff  = 2'd1;
          nxt   = S_RD2;
        end
      end
      S_RD2: begin
        dm_rd = 1'b1;
        woff  = 2'd2;
        nxt   = S_RD3;
      end
      S_RD3: begin
        dm_rd = 1'b1;
        woff  = 2'd3;
        nxt   = S_CHK;
      end
      S_CHK: begin
        if (!ptr_ok(dm_rdata[0], PORT_W)) begin
          ev_oddptr = 1'b1;
          nxt       = S_WB;
        end else begin
          u_load = 1'b1;
          nxt    = (len_q == 16'd0) ? S_WB : S_FETCH;
        end
      end
      S_FETCH: begin
        bm_rd = 1'b1;
        nxt   = S_CAP;
      end
      S_CAP: begin
        u_cap = 1'b1;
        nxt   = S_SEND;
      end
      S_SEND: begin
        out_valid = 1'b1;
        if (out_ready) begin
          u_adv = 1'b1;
          nxt   = u_last ? S_WB : S_FETCH;
        end
      end
      S_WB: begin
        dm_wr    = 1'b1;
        woff     = 2'd0;
        ev_close = 1'b1;
        nxt      = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign dm_addr  = tbl_base + {idx, woff};
  assign dm_wdata = close_status(st_q, err_q);
  assign out_end  = out_valid && st_q[ST_LAST] && u_last;
  assign ev_done  = ev_close && !err_q && st_q[ST_INT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      halted <= 1'b0;
      err_q  <= 1'b0;
      st_q   <= '0;
      len_q  <= '0;
      ptr_hi <= '0;
    end else begin
      state <= nxt;
      if (ev_notready) halted <= 1'b1;
      else if (state == S_IDLE && poll) halted <= 1'b0;
      if (state == S_RD1) st_q   <= dm_rdata;
      if (state == S_RD2) len_q  <= dm_rdata;
      if (state == S_RD3) ptr_hi <= dm_rdata;
      if (state == S_CHK) err_q  <= ev_oddptr;
      if (state == S_WB)  idx    <= st_q[ST_WRAP] ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DA_W   = 8,
  parameter int BA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              poll,
  input  logic [DA_W-1:0]   tbl_base,
  output logic [DA_W-1:0]   dm_addr,
  output logic              dm_rd,
  output logic              dm_wr,
  output logic [15:0]       dm_wdata,
  input  logic [15:0]       dm_rdata,
  output logic [BA_W-1:0]   bm_addr,
  output logic              bm_rd,
  input  logic [15:0]       bm_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_data,
  output logic              out_end,
  input  logic              evt_clr_we,
  input  logic [1:0]        evt_clr,
  input  logic [1:0]        evt_mask,
  output logic [1:0]        evt,
  output logic              irq
);

  // internal events, brought out for the checker
  logic            ev_notready, ev_oddptr, ev_close, ev_done;
  logic            u_load, u_cap, u_adv, u_last;
  logic [BA_W-1:0] u_ptr;
  logic [15:0]     u_len;
  logic [EV_N-1:0] ev_set;

  txr_seq #(.PORT_W(PORT_W), .DA_W(DA_W), .BA_W(BA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .poll       (poll),
    .tbl_base   (tbl_base),
    .dm_addr    (dm_addr),
    .dm_rd      (dm_rd),
    .dm_wr      (dm_wr),
    .dm_wdata   (dm_wdata),
    .dm_rdata   (dm_rdata),
    .bm_rd      (bm_rd),
    .u_load     (u_load),
    .u_ptr      (u_ptr),
    .u_len      (u_len),
    .u_cap      (u_cap),
    .u_adv      (u_adv),
    .u_last     (u_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_end    (out_end),
    .ev_notready(ev_notready),
    .ev_oddptr  (ev_oddptr),
    .ev_close   (ev_close),
    .ev_done    (ev_done)
  );

  txr_unit #(.PORT_W(PORT_W), .BA_W(BA_W)) u_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (u_load),
    .ld_ptr   (u_ptr),
    .ld_len   (u_len),
    .cap      (u_cap),
    .bm_rdata (bm_rdata),
    .adv      (u_adv),
    .bm_addr  (bm_addr),
    .last_u   (u_last),
    .unit_data(out_data)
  );

  assign ev_set[EV_DONE] = ev_done;
  assign ev_set[EV_ERR]  = ev_notready | ev_oddptr;

  txr_events #(.N(EV_N)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr_we(evt_clr_we),
    .clr   (evt_clr),
    .mask  (evt_mask),
    .evt   (evt),
    .irq   (irq)
  );

endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int PORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_data,
  input logic              out_end,
  input logic              dm_rd,
  input logic              dm_wr,
  input logic              wb_own,
  input logic [1:0]        evt,
  input logic              ev_notready,
  input logic              ev_oddptr
);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_end));

  // R5
  end_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> out_valid);

  // R5
  end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_end |=> !out_valid);

  // R1
  dm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_rd && dm_wr));

  // R2
  notready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_notready |=> evt[1] && !dm_wr && !out_valid);

  // R9
  oddptr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oddptr |=> dm_wr && !wb_own && !out_valid);

endmodule

bind txring_engine txr_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_end    (out_end),
  .dm_rd      (dm_rd),
  .dm_wr      (dm_wr),
  .wb_own     (dm_wdata[15]),
  .evt        (evt),
  .ev_notready(ev_notready),
  .ev_oddptr  (ev_oddptr)
);

// File: tb/tb_txring_engine.sv
module tb_txring_engine;

  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, INTR = 16'h1000,
                          LST = 16'h0800, CNT = 16'h0200, RSV = 16'h44F0;
  localparam logic [7:0]  BASE_A = 8'h10, BASE_B = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // instance A: 16-bit port, instance B: 8-bit port
  logic        en_a = 0, poll_a = 0, clrwe_a = 0, en_b = 0, poll_b = 0, clrwe_b = 0;
  logic [1:0]  clr_a = 0, mask_a = 0, clr_b = 0, mask_b = 0;
  logic        rdy_a = 0, rdy_b = 0;
  logic [7:0]  dma_a, dma_b;
  logic        dmr_a, dmw_a, dmr_b, dmw_b, bmr_a, bmr_b;
  logic [15:0] dmwd_a, dmwd_b, dmrd_a, dmrd_b, bmrd_a, bmrd_b;
  logic [31:0] bma_a, bma_b;
  logic        ov_a, ov_b, oe_a, oe_b, irq_a, irq_b;
  logic [15:0] od_a;
  logic [7:0]  od_b;
  logic [1:0]  evt_a, evt_b;

  logic [15:0] dmem_a [256];
  logic [15:0] dmem_b [256];
  logic [16:0] expa[$];
  logic [16:0] expb[$];

  txring_engine #(.PORT_W(16), .DA_W(8), .BA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .enable(en_a), .poll(poll_a), .tbl_base(BASE_A),
    .dm_addr(dma_a), .dm_rd(dmr_a), .dm_wr(dmw_a), .dm_wdata(dmwd_a), .dm_rdata(dmrd_a),
    .bm_addr(bma_a), .bm_rd(bmr_a), .bm_rdata(bmrd_a),
    .out_valid(ov_a), .out_ready(rdy_a), .out_data(od_a), .out_end(oe_a),
    .evt_clr_we(clrwe_a), .evt_clr(clr_a), .evt_mask(mask_a), .evt(evt_a), .irq(irq_a));

  txring_engine #(.PORT_W(8), .DA_W(8), .BA_W(32)) dut_b (
    .clk(clk), .rst_n(rst_n), .enable(en_b), .poll(poll_b), .tbl_base(BASE_B),
    .dm_addr(dma_b), .dm_rd(dmr_b), .dm_wr(dmw_b), .dm_wdata(dmwd_b), .dm_rdata(dmrd_b),
    .bm_addr(bma_b), .bm_rd(bmr_b), .bm_rdata(bmrd_b),
    .out_valid(ov_b), .out_ready(rdy_b), .out_data(od_b), .out_end(oe_b),
    .evt_clr_we(clrwe_b), .evt_clr(clr_b), .evt_mask(mask_b), .evt(evt_b), .irq(irq_b));

  // buffer memory contents as a function of the byte address
  function automatic logic [7:0] bf(input int unsigned a);
    return 8'(a * 7 + 3) ^ 8'(a >> 8);
  endfunction

  // memory models, one cycle read latency
  always @(posedge clk) begin
    if (dmr_a) dmrd_a <= dmem_a[dma_a];
    if (dmw_a) dmem_a[dma_a] = dmwd_a;
    if (bmr_a) bmrd_a <= {bf(bma_a + 1), bf(bma_a)};
    if (dmr_b) dmrd_b <= dmem_b[dma_b];
    if (dmw_b) dmem_b[dma_b] = dmwd_b;
    if (bmr_b) bmrd_b <= {bf(bma_b + 1), bf(bma_b)};
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference output stream built from the requirements
  task automatic expect_buf(input int sel, input int unsigned ptr, input int len, input bit last);
    if (sel == 0) begin
      for (int k = 0; k < len; k += 2) begin
        logic [7:0] hi;
        hi = (k + 1 < len) ? bf(ptr + k + 1) : 8'h00;
        expa.push_back({last && (k + 2 >= len), hi, bf(ptr + k)});
      end
    end else begin
      for (int k = 0; k < len; k++)
        expb.push_back({last && (k == len - 1), 8'h00, bf(ptr + k)});
    end
  endtask

  task automatic wr_desc(input int sel, input int idx, input logic [15:0] st,
                         input logic [15:0] len, input logic [31:0] ptr);
    int b;
    b = (sel == 0 ? BASE_A : BASE_B) + 4 * idx;
    if (sel == 0) begin
      dmem_a[b] = st; dmem_a[b+1] = len; dmem_a[b+2] = ptr[31:16]; dmem_a[b+3] = ptr[15:0];
    end else begin
      dmem_b[b] = st; dmem_b[b+1] = len; dmem_b[b+2] = ptr[31:16]; dmem_b[b+3] = ptr[15:0];
    end
  endtask

  // per-clock comparison of the output port against the reference stream
  logic        hold_a = 0, hold_b = 0;
  logic [16:0] hd_a, hd_b;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_a) chk(ov_a && {oe_a, od_a} == hd_a, "R4 hold A", {ov_a, oe_a, od_a}, {1'b1, hd_a});
      if (hold_b) chk(ov_b && {oe_b, 8'h00, od_b} == hd_b, "R4 hold B", {ov_b, oe_b, od_b}, {1'b1, hd_b});
      hold_a = ov_a && !rdy_a; hd_a = {oe_a, od_a};
      hold_b = ov_b && !rdy_b; hd_b = {oe_b, 8'h00, od_b};
      if (ov_a && rdy_a) begin
        if (expa.size() == 0) chk(1'b0, "R3/R7 unexpected unit A", {oe_a, od_a}, 0);
        else begin
          logic [16:0] e;
          e = expa.pop_front();
          chk({oe_a, od_a} == e, "R3/R5 unit A", {oe_a, od_a}, e);
        end
      end
      if (ov_b && rdy_b) begin
        if (expb.size() == 0) chk(1'b0, "R10 unexpected unit B", {oe_b, od_b}, 0);
        else begin
          logic [16:0] e;
          e = expb.pop_front();
          chk({oe_b, 8'h00, od_b} == e, "R3/R5 unit B", {oe_b, 8'h00, od_b}, e);
        end
      end
      if (dmr_a && dmw_a) chk(1'b0, "R1 rd/wr overlap", 1, 0);
    end
  end

  // throttled output handshake
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      rdy_a = (cyc % 3) != 1;
      rdy_b = (cyc % 4) != 2;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_poll(input int sel);
    @(posedge clk); #1;
    if (sel == 0) poll_a = 1; else poll_b = 1;
    @(posedge clk); #1;
    poll_a = 0; poll_b = 0;
  endtask

  task automatic clear_evt(input int sel, input logic [1:0] bits);
    @(posedge clk); #1;
    if (sel == 0) begin clrwe_a = 1; clr_a = bits; end
    else begin clrwe_b = 1; clr_b = bits; end
    @(posedge clk); #1;
    clrwe_a = 0; clrwe_b = 0; clr_a = 0; clr_b = 0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin dmem_a[i] = 16'h0; dmem_b[i] = 16'h0; end
    wait_cyc(4);
    @(negedge clk);
    chk(!ov_a && !ov_b, "R4 reset valid", {ov_a, ov_b}, 0);
    chk(evt_a == 0 && evt_b == 0 && !irq_a, "R11 reset events", {evt_a, evt_b}, 0);
    rst_n = 1;
    wait_cyc(2);

    // ring A: three descriptors, last one wraps and is continuous; entry 3 must never be reached
    wr_desc(0, 0, RDY | INTR, 16'd5, 32'h0000_0100);
    wr_desc(0, 1, RDY | LST, 16'd4, 32'h0000_0120);
    wr_desc(0, 2, RDY | WRP | LST | CNT, 16'd3, 32'h0000_0140);
    wr_desc(0, 3, RDY | LST, 16'd2, 32'h0000_0180);
    expect_buf(0, 32'h100, 5, 0);
    expect_buf(0, 32'h120, 4, 1);
    expect_buf(0, 32'h140, 3, 1);
    en_a = 1;
    @(negedge clk);
    while (!dmr_a) @(negedge clk);
    chk(dma_a == BASE_A, "R1 first read at base", dma_a, BASE_A);
    wait_cyc(300);
    chk(expa.size() == 0, "R3/R7 stream A drained", expa.size(), 0);
    chk(dmem_a[BASE_A] == INTR, "R6 close clears owner", dmem_a[BASE_A], INTR);
    chk(dmem_a[BASE_A+4] == LST, "R6 close D1", dmem_a[BASE_A+4], LST);
    chk(dmem_a[BASE_A+8] == (RDY | WRP | LST | CNT), "R6 continuous keeps owner",
        dmem_a[BASE_A+8], RDY | WRP | LST | CNT);
    chk(evt_a == 2'b11, "R8/R2 events A", evt_a, 2'b11);
    chk(!irq_a, "R11 masked irq", irq_a, 0);
    mask_a = 2'b01;
    @(negedge clk);
    chk(irq_a, "R11 unmasked irq", irq_a, 1);
    clear_evt(0, 2'b10);
    @(negedge clk);
    chk(evt_a == 2'b01, "R11 write-one clear", evt_a, 2'b01);

    // re-arm entry 0; parked engine must re-read it only after a poll
    dmem_a[BASE_A] = RDY | INTR;
    wait_cyc(40);
    chk(dmem_a[BASE_A] == (RDY | INTR), "R2 parked without poll", dmem_a[BASE_A], RDY | INTR);
    expect_buf(0, 32'h100, 5, 0);
    pulse_poll(0);
    wait_cyc(200);
    chk(expa.size() == 0, "R2 same descriptor resent", expa.size(), 0);
    chk(evt_a == 2'b11, "R2 error on next not-ready", evt_a, 2'b11);

    // odd pointer on the 16-bit port, continuous bit set
    clear_evt(0, 2'b11);
    wr_desc(0, 1, RDY | CNT | LST, 16'd4, 32'h0000_0161);
    expect_buf(0, 32'h140, 3, 1);
    pulse_poll(0);
    wait_cyc(200);
    chk(dmem_a[BASE_A+4] == (CNT | LST), "R9 odd pointer releases", dmem_a[BASE_A+4], CNT | LST);
    chk(expa.size() == 0, "R9/R7 no data then next", expa.size(), 0);
    chk(evt_a == 2'b10, "R8 no done on error", evt_a, 2'b10);

    // ring B: 8-bit port, odd start, reserved bits, then a zero-length wrap entry
    wr_desc(1, 0, RDY | INTR | LST | RSV, 16'd3, 32'h0000_0203);
    wr_desc(1, 1, RDY | WRP, 16'd0, 32'h0000_0300);
    expect_buf(1, 32'h203, 3, 1);
    en_b = 1;
    wait_cyc(200);
    chk(expb.size() == 0, "R3/R5 stream B drained", expb.size(), 0);
    chk(dmem_b[BASE_B] == (INTR | LST | RSV), "R12 reserved kept", dmem_b[BASE_B], INTR | LST | RSV);
    chk(dmem_b[BASE_B+4] == WRP, "R10 zero length closed", dmem_b[BASE_B+4], WRP);
    chk(evt_b == 2'b11, "R8/R2 events B", evt_b, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule